// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Sequencer

This block produces the system reset pair and a watchdog-fault flag from a digitized supply-good flag and a three-state watchdog input. The supply-good flag, the watchdog level and the watchdog "floating" indication reach it as clean logic levels. All delays are measured in ticks of a selectable timebase. In external mode a one-cycle tick pulse is supplied at the port and the periods are fixed tick counts. In internal mode the block derives its own tick from the system clock through a prescaler, and a select input picks the watchdog period scheme.

Reset is held while the supply is bad and for a fixed period after it returns. The watchdog then starts with an extended first period. Each level change on the watchdog input restarts it and returns it to the normal period. If the input stops toggling, the block flags a fault and issues a reset pulse. An input that is held still produces a reset pulse after every watchdog period. A floating input disables the watchdog.

Top module: `sup_reset_wdog`

## Requirements
- R1: While `power_ok_i` is low, `rst_o` is 1 and `rst_no` is 0 from the first clock edge after it falls, and the two reset outputs are always complements.
- R2: After `power_ok_i` returns high, the resets stay asserted for the reset period: EXT_RST_CYC ticks in external mode (`ext_mode_i`=1), INT_RST_TICKS ticks in internal mode.
- R3: The first watchdog period after any reset release is EXT_WD_FIRST_CYC ticks in external mode and INT_WD_LONG_TICKS ticks in internal mode, whatever `sel_long_i` is.
- R4: After a watchdog input edge, the normal period applies. It is EXT_WD_CYC ticks in external mode. In internal mode it is INT_WD_LONG_TICKS with `sel_long_i`=1 and INT_WD_SHORT_TICKS with `sel_long_i`=0.
- R5: Any rising or falling change of `wdi_level_i` restarts the watchdog count, so edges spaced closer than the period never cause a reset.
- R6: On expiry, `wdo_no` falls together with the assertion of reset, and reset lasts one reset period. `wdo_no` stays low through that pulse and beyond it, until the next edge on `wdi_level_i`, which sets it high again.
- R7: With `wdi_level_i` held constant, reset pulses of one reset period repeat, separated by the after-reset watchdog period.
- R8: While `wdi_float_i` is 1, the watchdog does not count, `wdo_no` stays 1 and no reset is issued.
- R9: While `power_ok_i` is low, `wdo_no` is forced to 1.
- R10: Counters advance only on a tick. In external mode this is `tick_i`; in internal mode it is one pulse every PRESCALE clock cycles. With `tick_i` held low in external mode, reset never releases.
- R11: An active-low `rst_ni` asynchronously puts the block into the asserted-reset state with `wdo_no`=1 and all counters cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low block reset |
| tick_i | input | 1 | One-cycle timebase pulse, used in external mode |
| ext_mode_i | input | 1 | 1: fixed tick counts from `tick_i`; 0: internal prescaled timebase |
| sel_long_i | input | 1 | Internal mode: 1 long period always, 0 short normal period |
| power_ok_i | input | 1 | Supply-good flag |
| wdi_level_i | input | 1 | Watchdog input logic level |
| wdi_float_i | input | 1 | Watchdog input is floating (disables watchdog) |
| rst_o | output | 1 | Active-high reset |
| rst_no | output | 1 | Active-low reset |
| wdo_no | output | 1 | Active-low watchdog fault flag |

## Verification
The assertions check on every cycle the properties that are local in time. A supply loss forces reset and a high fault flag on the next edge. A falling fault flag coincides with asserted reset. A fault flag only rises after an input edge, a float or a supply loss. Reset only releases on a tick with supply good, and no fault arises while the input floats. The exact lengths of the reset period, the first and normal watchdog periods in each timebase mode, and the repeating pulse train are shown only by the bench's scenarios. So are the suppression of expiry by closely spaced edges and the stalled release without ticks.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic {ST_HOLD = 1'b0, ST_RUN = 1'b1} sup_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sup_timebase.sv
module sup_timebase #(
  parameter int unsigned PRESCALE = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_mode_i,
  input  logic tick_i,
  output logic tick_o
);
  logic int_tick;

  generate
    if (PRESCALE <= 1) begin : g_direct
      assign int_tick = 1'b1;
    end else begin : g_prescale
      localparam int unsigned PW = $clog2(PRESCALE);
      logic [PW-1:0] cnt_q;
      logic          pulse_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          cnt_q   <= '0;
          pulse_q <= 1'b0;
        end else begin
          pulse_q <= (cnt_q == PW'(PRESCALE - 1));
          cnt_q   <= (cnt_q == PW'(PRESCALE - 1)) ? '0 : cnt_q + 1'b1;
        end
      end
      assign int_tick = pulse_q;
    end
  endgenerate

  assign tick_o = ext_mode_i ? tick_i : int_tick;
endmodule

// File: rtl/sup_wdi_edge.sv
module sup_wdi_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wdi_level_i,
  output logic edge_o
);
  logic wdi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wdi_q <= 1'b0;
    else         wdi_q <= wdi_level_i;
  end

  assign edge_o = wdi_level_i ^ wdi_q;
endmodule

// File: rtl/sup_period_sel.sv
module sup_period_sel #(
  parameter int unsigned EXT_RST_CYC        = 2048,
  parameter int unsigned EXT_WD_CYC         = 1024,
  parameter int unsigned EXT_WD_FIRST_CYC   = 4096,
  parameter int unsigned INT_RST_TICKS      = 200,
  parameter int unsigned INT_WD_LONG_TICKS  = 1600,
  parameter int unsigned INT_WD_SHORT_TICKS = 100,
  parameter int unsigned RCW                = 12,
  parameter int unsigned WCW                = 13
) (
  input  logic           ext_mode_i,
  input  logic           sel_long_i,
  input  logic           first_i,
  output logic [RCW-1:0] rst_per_o,
  output logic [WCW-1:0] wd_per_o
);
  always_comb begin
    if (ext_mode_i) begin
      rst_per_o = RCW'(EXT_RST_CYC);
      wd_per_o  = first_i ? WCW'(EXT_WD_FIRST_CYC) : WCW'(EXT_WD_CYC);
    end else begin
      rst_per_o = RCW'(INT_RST_TICKS);
      wd_per_o  = (first_i || sel_long_i) ? WCW'(INT_WD_LONG_TICKS)
                                          : WCW'(INT_WD_SHORT_TICKS);
    end
  end
endmodule

// File: rtl/sup_seq.sv
module sup_seq
  import sup_pkg::*;
#(
  parameter int unsigned RCW = 12,
  parameter int unsigned WCW = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           tick_i,
  input  logic           power_ok_i,
  input  logic           wdi_edge_i,
  input  logic           wdi_float_i,
  input  logic [RCW-1:0] rst_per_i,
  input  logic [WCW-1:0] wd_per_i,
  output logic           first_o,
  output logic           hold_o,
  output logic           wdo_no
);
  sup_state_e     state_q;
  logic [RCW-1:0] rst_cnt_q;
  logic [WCW-1:0] wd_cnt_q;
  logic           first_q;
  logic           wdo_n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_HOLD;
      rst_cnt_q <= '0;
      wd_cnt_q  <= '0;
      first_q   <= 1'b1;
      wdo_n_q   <= 1'b1;
    end else if (!power_ok_i) begin
      state_q   <= ST_HOLD;
      rst_cnt_q <= '0;
      wd_cnt_q  <= '0;
      first_q   <= 1'b1;
      wdo_n_q   <= 1'b1;
    end else begin
      unique case (state_q)
        ST_HOLD: begin
          if (wdi_float_i || wdi_edge_i) wdo_n_q <= 1'b1;
          if (tick_i) begin
            if (rst_cnt_q >= rst_per_i - RCW'(1)) begin
              state_q   <= ST_RUN;
              rst_cnt_q <= '0;
              wd_cnt_q  <= '0;
            end else begin
              rst_cnt_q <= rst_cnt_q + 1'b1;
            end
          end
        end
        ST_RUN: begin
          if (wdi_float_i) begin
            wd_cnt_q <= '0;
            wdo_n_q  <= 1'b1;
          end else if (wdi_edge_i) begin
            // edge restarts and leaves the after-reset period
            wd_cnt_q <= '0;
            first_q  <= 1'b0;
            wdo_n_q  <= 1'b1;
          end else if (tick_i) begin
            if (wd_cnt_q >= wd_per_i - WCW'(1)) begin
              state_q  <= ST_HOLD;
              wd_cnt_q <= '0;
              first_q  <= 1'b1;
              wdo_n_q  <= 1'b0;
            end else begin
              wd_cnt_q <= wd_cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_HOLD;
      endcase
    end
  end

  assign first_o = first_q;
  assign hold_o  = (state_q == ST_HOLD);
  assign wdo_no  = wdo_n_q;
endmodule

// File: rtl/sup_reset_wdog.sv
module sup_reset_wdog
  import sup_pkg::*;
#(
  parameter int unsigned EXT_RST_CYC        = 2048,
  parameter int unsigned EXT_WD_CYC         = 1024,
  parameter int unsigned EXT_WD_FIRST_CYC   = 4096,
  parameter int unsigned INT_RST_TICKS      = 200,
  parameter int unsigned INT_WD_LONG_TICKS  = 1600,
  parameter int unsigned INT_WD_SHORT_TICKS = 100,
  parameter int unsigned PRESCALE           = 50000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic ext_mode_i,
  input  logic sel_long_i,
  input  logic power_ok_i,
  input  logic wdi_level_i,
  input  logic wdi_float_i,
  output logic rst_o,
  output logic rst_no,
  output logic wdo_no
);
  localparam int unsigned WD_MAX  = max2(max2(EXT_WD_FIRST_CYC, EXT_WD_CYC),
                                         max2(INT_WD_LONG_TICKS, INT_WD_SHORT_TICKS));
  localparam int unsigned RST_MAX = max2(EXT_RST_CYC, INT_RST_TICKS);
  localparam int unsigned WCW     = $clog2(WD_MAX + 1);
  localparam int unsigned RCW     = $clog2(RST_MAX + 1);

  logic           tick;
  logic           wdi_edge;
  logic           first;
  logic           hold;
  logic [RCW-1:0] rst_per;
  logic [WCW-1:0] wd_per;

  sup_timebase #(.PRESCALE(PRESCALE)) u_tb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_mode_i (ext_mode_i),
    .tick_i     (tick_i),
    .tick_o     (tick)
  );

  sup_wdi_edge u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wdi_level_i (wdi_level_i),
    .edge_o      (wdi_edge)
  );

  sup_period_sel #(
    .EXT_RST_CYC        (EXT_RST_CYC),
    .EXT_WD_CYC         (EXT_WD_CYC),
    .EXT_WD_FIRST_CYC   (EXT_WD_FIRST_CYC),
    .INT_RST_TICKS      (INT_RST_TICKS),
    .INT_WD_LONG_TICKS  (INT_WD_LONG_TICKS),
    .INT_WD_SHORT_TICKS (INT_WD_SHORT_TICKS),
    .RCW                (RCW),
    .WCW                (WCW)
  ) u_per (
    .ext_mode_i (ext_mode_i),
    .sel_long_i (sel_long_i),
    .first_i    (first),
    .rst_per_o  (rst_per),
    .wd_per_o   (wd_per)
  );

  sup_seq #(.RCW(RCW), .WCW(WCW)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .power_ok_i  (power_ok_i),
    .wdi_edge_i  (wdi_edge),
    .wdi_float_i (wdi_float_i),
    .rst_per_i   (rst_per),
    .wd_per_i    (wd_per),
    .first_o     (first),
    .hold_o      (hold),
    .wdo_no      (wdo_no)
  );

  assign rst_o  = hold;
  assign rst_no = ~hold;
endmodule

// File: rtl/sup_reset_wdog_chk.sv
module sup_reset_wdog_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tick,
  input logic power_ok_i,
  input logic wdi_level_i,
  input logic wdi_float_i,
  input logic rst_o,
  input logic wdo_no
);
  // R1
  p_pwr_loss_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !power_ok_i |=> rst_o);

  // R9
  p_wdo_pwr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !power_ok_i |=> wdo_no);

  // R6: fault and reset appear together
  p_fault_rst_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdo_no) |-> rst_o);

  // R6: fault clears only on edge, float or supply loss
  p_fault_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wdo_no) |-> ($past(!power_ok_i) || $past(wdi_float_i) ||
                       ($past(wdi_level_i) != $past(wdi_level_i, 2))));

  // R8
  p_no_fault_float_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wdo_no) |-> $past(!wdi_float_i && power_ok_i));

  // R10
  p_release_tick_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rst_o) |-> $past(tick && power_ok_i));
endmodule

bind sup_reset_wdog sup_reset_wdog_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tick        (tick),
  .power_ok_i  (power_ok_i),
  .wdi_level_i (wdi_level_i),
  .wdi_float_i (wdi_float_i),
  .rst_o       (rst_o),
  .wdo_no      (wdo_no)
);

// File: tb/sup_reset_wdog_tb.sv
module sup_reset_wdog_tb;
  localparam int unsigned EXT_RST   = 2048;
  localparam int unsigned EXT_WD    = 1024;
  localparam int unsigned EXT_FIRST = 4096;
  localparam int unsigned INT_RST   = 5;
  localparam int unsigned INT_LONG  = 20;
  localparam int unsigned INT_SHORT = 6;
  localparam int unsigned PRE       = 2;

  typedef struct packed {
    logic        ext;
    logic        sel;
    int unsigned rst_t;
    int unsigned first_t;
    int unsigned norm_t;
    int unsigned scale;
  } row_t;

  localparam row_t ROWS [3] = '{
    '{1'b1, 1'b0, EXT_RST, EXT_FIRST, EXT_WD,    1},
    '{1'b0, 1'b1, INT_RST, INT_LONG,  INT_LONG,  PRE},
    '{1'b0, 1'b0, INT_RST, INT_LONG,  INT_SHORT, PRE}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tick_i = 1'b1;
  logic ext_mode_i = 1'b1;
  logic sel_long_i = 1'b0;
  logic power_ok_i = 1'b1;
  logic wdi_level_i = 1'b0;
  logic wdi_float_i = 1'b0;
  logic rst_o, rst_no, wdo_no;

  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  sup_reset_wdog #(
    .EXT_RST_CYC        (EXT_RST),
    .EXT_WD_CYC         (EXT_WD),
    .EXT_WD_FIRST_CYC   (EXT_FIRST),
    .INT_RST_TICKS      (INT_RST),
    .INT_WD_LONG_TICKS  (INT_LONG),
    .INT_WD_SHORT_TICKS (INT_SHORT),
    .PRESCALE           (PRE)
  ) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .ext_mode_i  (ext_mode_i),
    .sel_long_i  (sel_long_i),
    .power_ok_i  (power_ok_i),
    .wdi_level_i (wdi_level_i),
    .wdi_float_i (wdi_float_i),
    .rst_o       (rst_o),
    .rst_no      (rst_no),
    .wdo_no      (wdo_no)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_win(input string req, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // counts posedges until rst_o equals val, sampled 1 ns after each edge
  task automatic cnt_until(input logic val, output int n);
    n = 0;
    do begin
      @(posedge clk);
      #1;
      n++;
    end while (rst_o !== val && n < 30000);
  endtask

  task automatic toggle_wdi();
    @(negedge clk);
    wdi_level_i = ~wdi_level_i;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  initial begin
    int n;
    int lo;
    int hi;
    logic bad;

    // R11: reset state
    repeat (4) @(posedge clk);
    #1;
    chk_bit("R11 rst_o", rst_o, 1'b1);
    chk_bit("R11 rst_no", rst_no, 1'b0);
    chk_bit("R11 wdo_no", wdo_no, 1'b1);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int r = 0; r < 3; r++) begin
      @(negedge clk);
      ext_mode_i  = ROWS[r].ext;
      sel_long_i  = ROWS[r].sel;
      power_ok_i  = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      chk_bit("R1 rst_o on supply loss", rst_o, 1'b1);
      chk_bit("R1 rst_no on supply loss", rst_no, 1'b0);
      chk_bit("R9 wdo_no on supply loss", wdo_no, 1'b1);

      @(negedge clk);
      power_ok_i = 1'b1;
      cnt_until(1'b0, n);
      lo = int'(ROWS[r].rst_t * ROWS[r].scale - (ROWS[r].scale - 1));
      hi = int'(ROWS[r].rst_t * ROWS[r].scale);
      chk_win("R2 reset period", n, lo, hi);
      chk_bit("R1 complement", rst_no, ~rst_o);

      cnt_until(1'b1, n);
      chk_win("R3 first watchdog period", n, int'(ROWS[r].first_t * ROWS[r].scale),
              int'(ROWS[r].first_t * ROWS[r].scale));
      chk_bit("R6 fault with reset", wdo_no, 1'b0);

      cnt_until(1'b0, n);
      chk_win("R6 watchdog reset pulse", n, int'(ROWS[r].rst_t * ROWS[r].scale),
              int'(ROWS[r].rst_t * ROWS[r].scale));
      chk_bit("R6 fault stays low", wdo_no, 1'b0);

      cnt_until(1'b1, n);
      chk_win("R7 repeat period", n, int'(ROWS[r].first_t * ROWS[r].scale),
              int'(ROWS[r].first_t * ROWS[r].scale));
      cnt_until(1'b0, n);

      // edge clears fault, then normal period
      toggle_wdi();
      @(posedge clk);
      #1;
      chk_bit("R6 edge clears fault", wdo_no, 1'b1);
      cnt_until(1'b1, n);
      lo = int'(ROWS[r].norm_t * ROWS[r].scale - (ROWS[r].scale - 1));
      hi = int'(ROWS[r].norm_t * ROWS[r].scale);
      chk_win("R4 normal period", n, lo, hi);
      cnt_until(1'b0, n);

      // R5: closely spaced edges keep the watchdog quiet
      bad = 1'b0;
      toggle_wdi();
      for (int k = 0; k < 12; k++) begin
        repeat (int'(ROWS[r].norm_t * ROWS[r].scale - ROWS[r].scale)) begin
          @(negedge clk);
          if (rst_o !== 1'b0 || wdo_no !== 1'b1) bad = 1'b1;
        end
        wdi_level_i = ~wdi_level_i;
      end
      chk_bit("R5 edges restart timer", bad, 1'b0);

      // R8: floating input disables watchdog
      @(negedge clk);
      wdi_float_i = 1'b1;
      bad = 1'b0;
      repeat (int'(3 * ROWS[r].first_t * ROWS[r].scale)) begin
        @(negedge clk);
        if (rst_o !== 1'b0 || wdo_no !== 1'b1) bad = 1'b1;
      end
      chk_bit("R8 floating disables", bad, 1'b0);
      wdi_float_i = 1'b0;
    end

    // R10: no tick, no release
    @(negedge clk);
    ext_mode_i = 1'b1;
    tick_i     = 1'b0;
    power_ok_i = 1'b0;
    @(negedge clk);
    power_ok_i = 1'b1;
    repeat (5000) @(negedge clk);
    chk_bit("R10 held without ticks", rst_o, 1'b1);
    tick_i = 1'b1;
    cnt_until(1'b0, n);
    chk_win("R10 release after ticks", n, int'(EXT_RST), int'(EXT_RST));

    // R11: asynchronous block reset mid-run
    repeat (10) @(negedge clk);
    #1;
    rst_ni = 1'b0;
    #0.5;
    chk_bit("R11 async rst_o", rst_o, 1'b1);
    chk_bit("R11 async rst_no", rst_no, 1'b0);
    chk_bit("R11 async wdo_no", wdo_no, 1'b1);
    @(negedge clk);
    rst_ni = 1'b1;

    summary();
    $finish;
  end
endmodule